// File: doc/BRIEF.md
# Acquisition and Generation Trigger Unit

This unit decides when a pattern engine starts, when it pauses and where its reference point lies. Three trigger channels each pick their own source: one of several external digital lines, a masked comparison of the data bus against a stored pattern, or nothing at all. The start and reference channels react to transitions, while the pause channel reacts to a level. Each channel has a sense bit that selects between the two polarities of its condition.

A run lasts as long as `arm` is held high, and each cycle with `smp_en` high counts as one sample. The unit emits a one-cycle start strobe and a one-cycle reference strobe, and it holds a paused level that follows the pause condition after a fixed pipeline latency counted in samples. A data-active flag reports, sample by sample, whether the engine is really producing data. When generation mode is selected, the pattern source is refused, and a reject flag shows this to the configuring logic.

Top module: `seq_trigger_unit`

## Requirements
- R1: The pattern comparison matches when `(data_in ^ pat_value) & pat_care` is zero. Bits cleared in `pat_care` always compare equal.
- R2: Each source field uses this encoding: 0 is off, 1 is the external line `ext_lines[sel]`, 2 is the pattern comparison, and 3 is off. For an edge channel on a line, sense 0 detects a rising edge and sense 1 detects a falling edge, both judged between consecutive samples of the same run. The first sample of a run can never be an edge.
- R3: A pattern start or reference trigger fires on the first sample where the comparison result changes to the selected sense (sense 0 = match, sense 1 = mismatch). It does not fire on samples where that result merely persists.
- R4: When the start source is off, start fires on the first sample of the run. When the reference source is off, no reference strobe occurs. When the pause source is off, the unit never pauses.
- R5: `start_stb` is high for exactly one cycle, on the cycle after the sample that fired it, and at most once per run. Dropping `arm` ends the run and clears all outputs on the next cycle. Raising `arm` again starts a new run.
- R6: The reference trigger is ignored until start has fired. It fires at most once per run, as a one-cycle `ref_stb`.
- R7: Pause is level-sensitive. With sense 0 the condition is line high or pattern match, and with sense 1 it is line low or pattern mismatch. Only samples taken after start count. `paused` rises after the PAUSE_LAT-th sample edge, counting the edge that captured the condition, and it falls the same way once the condition ends.
- R8: `data_active` is high exactly when start has fired in the current run and `paused` is low.
- R9: When `gen_mode` is 1, any channel set to the pattern source never fires, and `cfg_reject` is high.
- R10: Cycles with `smp_en` low change no trigger state. Strobes, the pause pipeline and edge history advance only on samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Run enable, high for the length of one run |
| gen_mode | input | 1 | 1 = generation (pattern source refused), 0 = acquisition |
| smp_en | input | 1 | Sample qualifier |
| data_in | input | DW | Data bus sampled for the pattern comparison |
| ext_lines | input | NL | External trigger lines |
| pat_value | input | DW | Pattern to compare against |
| pat_care | input | DW | Care mask, 1 = bit is compared |
| start_src | input | 2 | Start source code |
| start_sel | input | LW | Start line index |
| start_sense | input | 1 | Start polarity |
| pause_src | input | 2 | Pause source code |
| pause_sel | input | LW | Pause line index |
| pause_sense | input | 1 | Pause polarity |
| ref_src | input | 2 | Reference source code |
| ref_sel | input | LW | Reference line index |
| ref_sense | input | 1 | Reference polarity |
| start_stb | output | 1 | One-cycle start strobe |
| ref_stb | output | 1 | One-cycle reference strobe |
| paused | output | 1 | Engine paused level |
| data_active | output | 1 | Engine producing data |
| cfg_reject | output | 1 | Pattern source selected while in generation mode |

## Verification
A scripted run places a line start edge next to a falling edge, a skipped sample and a repeated edge, so that edge detection can be told apart from level detection and from counting non-sample cycles. A data bus that matches, stops matching and matches again separates the first transition from a held match, and also separates a single reference strobe from repeated ones. A pause level held for several samples and then removed shows the latency in both directions. Directed cases then cover:
- data that differs only in masked bits, which separates care-mask handling from a plain equality test;
- mismatch sense;
- off and reserved source codes;
- a reference edge before start, which separates gating from free-running detection;
- the generation-mode refusal.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_LINE = 2'd1,
    SRC_PAT  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  // raw condition before polarity is applied
  function automatic logic pick_raw(src_e s, logic line_v, logic pat_v);
    case (s)
      SRC_LINE: pick_raw = line_v;
      SRC_PAT:  pick_raw = pat_v;
      default:  pick_raw = 1'b0;
    endcase
  endfunction

  // a source can fire only if it is a line, or a pattern while acquiring
  function automatic logic src_usable(src_e s, logic gen);
    src_usable = (s == SRC_LINE) || ((s == SRC_PAT) && !gen);
  endfunction

  function automatic logic src_off(src_e s);
    src_off = (s == SRC_OFF) || (s == SRC_RSVD);
  endfunction

  // sense 0 keeps the raw value, sense 1 inverts it
  function automatic logic polarize(logic raw, logic sense);
    polarize = raw ^ sense;
  endfunction

  // transition of the polarized condition from 0 to 1
  function automatic logic became_true(logic now_v, logic prev_v, logic hist_v);
    became_true = hist_v && now_v && !prev_v;
  endfunction

endpackage

// File: rtl/seq_pat_cmp.sv
module seq_pat_cmp #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] value_i,
  input  logic [DW-1:0] care_i,
  output logic          hit_o
);

  logic [DW-1:0] diff_bits;

  assign diff_bits = (data_i ^ value_i) & care_i;
  assign hit_o     = (diff_bits == '0);

endmodule

// File: rtl/seq_edge_trig.sv
module seq_edge_trig
  import seq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       smp,
  input  logic [1:0] src,
  input  logic       sense,
  input  logic       line_val,
  input  logic       pat_hit,
  input  logic       gen_mode,
  output logic       hit
);

  src_e s;
  logic cond_now;
  logic cond_prev;
  logic hist_ok;

  assign s        = src_e'(src);
  assign cond_now = polarize(pick_raw(s, line_val, pat_hit), sense);
  assign hit      = src_usable(s, gen_mode) && became_true(cond_now, cond_prev, hist_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_prev <= 1'b0;
      hist_ok   <= 1'b0;
    end else if (clr) begin
      cond_prev <= 1'b0;
      hist_ok   <= 1'b0;
    end else if (smp) begin
      cond_prev <= cond_now;
      hist_ok   <= 1'b1;
    end
  end

endmodule

// File: rtl/seq_pause_pipe.sv
module seq_pause_pipe
  import seq_trig_pkg::*;
#(
  parameter int LAT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       smp,
  input  logic       started,
  input  logic [1:0] src,
  input  logic       sense,
  input  logic       line_val,
  input  logic       pat_hit,
  input  logic       gen_mode,
  output logic       paused
);

  src_e           s;
  logic           cond;
  logic [LAT-1:0] pipe;

  assign s      = src_e'(src);
  assign cond   = started && src_usable(s, gen_mode) &&
                  polarize(pick_raw(s, line_val, pat_hit), sense);
  assign paused = pipe[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pipe <= '0;
    else if (clr)    pipe <= '0;
    else if (smp)    pipe <= {pipe[LAT-2:0], cond};
  end

endmodule

// File: rtl/seq_trigger_unit.sv
module seq_trigger_unit
  import seq_trig_pkg::*;
#(
  parameter int DW        = 32,
  parameter int NL        = 8,
  parameter int PAUSE_LAT = 6,
  localparam int LW       = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          gen_mode,
  input  logic          smp_en,
  input  logic [DW-1:0] data_in,
  input  logic [NL-1:0] ext_lines,
  input  logic [DW-1:0] pat_value,
  input  logic [DW-1:0] pat_care,
  input  logic [1:0]    start_src,
  input  logic [LW-1:0] start_sel,
  input  logic          start_sense,
  input  logic [1:0]    pause_src,
  input  logic [LW-1:0] pause_sel,
  input  logic          pause_sense,
  input  logic [1:0]    ref_src,
  input  logic [LW-1:0] ref_sel,
  input  logic          ref_sense,
  output logic          start_stb,
  output logic          ref_stb,
  output logic          paused,
  output logic          data_active,
  output logic          cfg_reject
);

  logic pat_hit;
  logic start_hit;
  logic ref_hit;
  logic start_fire;
  logic ref_fire;
  logic started;
  logic ref_done;
  logic run_clr;

  assign run_clr = !arm;

  seq_pat_cmp #(.DW(DW)) u_cmp (
    .data_i  (data_in),
    .value_i (pat_value),
    .care_i  (pat_care),
    .hit_o   (pat_hit)
  );

  seq_edge_trig u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (run_clr),
    .smp      (smp_en),
    .src      (start_src),
    .sense    (start_sense),
    .line_val (ext_lines[start_sel]),
    .pat_hit  (pat_hit),
    .gen_mode (gen_mode),
    .hit      (start_hit)
  );

  seq_edge_trig u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (run_clr),
    .smp      (smp_en),
    .src      (ref_src),
    .sense    (ref_sense),
    .line_val (ext_lines[ref_sel]),
    .pat_hit  (pat_hit),
    .gen_mode (gen_mode),
    .hit      (ref_hit)
  );

  seq_pause_pipe #(.LAT(PAUSE_LAT)) u_pause (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (run_clr),
    .smp      (smp_en),
    .started  (started),
    .src      (pause_src),
    .sense    (pause_sense),
    .line_val (ext_lines[pause_sel]),
    .pat_hit  (pat_hit),
    .gen_mode (gen_mode),
    .paused   (paused)
  );

  // named trigger events
  assign start_fire = arm && smp_en && !started &&
                      (start_hit || src_off(src_e'(start_src)));
  assign ref_fire   = arm && smp_en && started && !ref_done && ref_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      ref_done  <= 1'b0;
      start_stb <= 1'b0;
      ref_stb   <= 1'b0;
    end else begin
      start_stb <= start_fire;
      ref_stb   <= ref_fire;
      if (run_clr) begin
        started  <= 1'b0;
        ref_done <= 1'b0;
      end else begin
        if (start_fire) started  <= 1'b1;
        if (ref_fire)   ref_done <= 1'b1;
      end
    end
  end

  assign data_active = started && !paused;
  assign cfg_reject  = gen_mode && ((src_e'(start_src) == SRC_PAT) ||
                                    (src_e'(pause_src) == SRC_PAT) ||
                                    (src_e'(ref_src)   == SRC_PAT));

endmodule

// File: rtl/seq_trigger_unit_chk.sv
module seq_trigger_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       smp_en,
  input logic       gen_mode,
  input logic [1:0] start_src,
  input logic       started,
  input logic       start_stb,
  input logic       ref_stb,
  input logic       paused,
  input logic       data_active
);

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb);

  a_r5_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!start_stb && !ref_stb && !paused && !data_active));

  a_r6_ref_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |-> started);

  a_r6_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> !ref_stb);

  a_r9_gen_no_pat_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gen_mode && (start_src == 2'd2) && smp_en) |-> !start_stb);

  a_r10_pause_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(smp_en));

  a_r10_pause_fall_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> ($past(smp_en) || !$past(arm)));

  a_r8_active_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    data_active |-> started);

endmodule

bind seq_trigger_unit seq_trigger_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm         (arm),
  .smp_en      (smp_en),
  .gen_mode    (gen_mode),
  .start_src   (start_src),
  .started     (started),
  .start_stb   (start_stb),
  .ref_stb     (ref_stb),
  .paused      (paused),
  .data_active (data_active)
);

// File: tb/test_seq_trigger_unit.sv
module test_seq_trigger_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        gen_mode = 1'b0;
  logic        smp_en = 1'b0;
  logic [31:0] data_in = '0;
  logic [7:0]  ext_lines = '0;
  logic [31:0] pat_value = '0;
  logic [31:0] pat_care = '0;
  logic [1:0]  start_src = 2'd0, pause_src = 2'd0, ref_src = 2'd0;
  logic [2:0]  start_sel = 3'd0, pause_sel = 3'd0, ref_sel = 3'd0;
  logic        start_sense = 1'b0, pause_sense = 1'b0, ref_sense = 1'b0;
  logic        start_stb, ref_stb, paused, data_active, cfg_reject;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seq_trigger_unit i_seq_trigger_unit (
    .clk(clk), .rst_n(rst_n), .arm(arm), .gen_mode(gen_mode), .smp_en(smp_en),
    .data_in(data_in), .ext_lines(ext_lines), .pat_value(pat_value), .pat_care(pat_care),
    .start_src(start_src), .start_sel(start_sel), .start_sense(start_sense),
    .pause_src(pause_src), .pause_sel(pause_sel), .pause_sense(pause_sense),
    .ref_src(ref_src), .ref_sel(ref_sel), .ref_sense(ref_sense),
    .start_stb(start_stb), .ref_stb(ref_stb), .paused(paused),
    .data_active(data_active), .cfg_reject(cfg_reject)
  );

  // row: arm, smp, lines, data, expected {start, ref, paused, active}
  localparam logic [45:0] TBL [21] = '{
    {1'b1, 1'b1, 8'h01, 32'h0000_0000, 4'b0000},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0000},
    {1'b1, 1'b0, 8'h01, 32'h0000_0000, 4'b0000},
    {1'b1, 1'b1, 8'h01, 32'h0000_0000, 4'b1001},
    {1'b1, 1'b1, 8'h00, 32'hA5A5_1234, 4'b0101},
    {1'b1, 1'b1, 8'h01, 32'hA5A5_0000, 4'b0001},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0001},
    {1'b1, 1'b1, 8'h00, 32'hA5A5_FFFF, 4'b0001},
    {1'b1, 1'b1, 8'h02, 32'h0000_0000, 4'b0001},
    {1'b1, 1'b1, 8'h02, 32'h0000_0000, 4'b0001},
    {1'b1, 1'b1, 8'h02, 32'h0000_0000, 4'b0001},
    {1'b1, 1'b1, 8'h02, 32'h0000_0000, 4'b0001},
    {1'b1, 1'b1, 8'h02, 32'h0000_0000, 4'b0001},
    {1'b1, 1'b1, 8'h02, 32'h0000_0000, 4'b0010},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0010},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0010},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0010},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0010},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0010},
    {1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'b0001},
    {1'b0, 1'b1, 8'h00, 32'h0000_0000, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic outs(input string req, input logic [3:0] exp);
    chk(req, {28'd0, start_stb, ref_stb, paused, data_active}, {28'd0, exp});
  endtask

  task automatic sample(input logic [7:0] ln, input logic [31:0] d);
    smp_en = 1'b1; ext_lines = ln; data_in = d;
    @(posedge clk); #2;
    smp_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      smp_en = 1'b0;
      @(posedge clk); #2;
    end
  endtask

  task automatic rearm();
    arm = 1'b0; idle(1);
    arm = 1'b1; idle(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    outs("R5 reset state", 4'b0000);
    chk("R9 reset reject", {31'd0, cfg_reject}, 32'd0);
    rst_n = 1'b1;
    idle(1);

    // scripted run: start line0 rising, ref pattern match, pause line1 high
    start_src = 2'd1; start_sel = 3'd0; start_sense = 1'b0;
    ref_src = 2'd2; ref_sense = 1'b0;
    pat_value = 32'hA5A5_0000; pat_care = 32'hFFFF_0000;
    pause_src = 2'd1; pause_sel = 3'd1; pause_sense = 1'b0;
    for (int r = 0; r < 21; r++) begin
      arm = TBL[r][45]; smp_en = TBL[r][44];
      ext_lines = TBL[r][43:36]; data_in = TBL[r][35:4];
      @(posedge clk); #2;
      outs($sformatf("R2 R3 R6 R7 R8 table row %0d", r), TBL[r][3:0]);
    end
    smp_en = 1'b0; arm = 1'b0; idle(1);

    // R1: differences confined to masked-off bits still match
    ref_src = 2'd0; pause_src = 2'd0;
    start_src = 2'd2; start_sense = 1'b0;
    pat_value = 32'h0000_00FF; pat_care = 32'h0000_00FF;
    rearm();
    sample(8'h00, 32'h0000_0000);
    outs("R1 mismatch no start", 4'b0000);
    sample(8'h00, 32'hABCD_12FF);
    outs("R1 masked match starts", 4'b1001);

    // R3: held match does not fire; a fresh transition does
    pat_value = 32'h0; pat_care = 32'hFFFF_FFFF;
    rearm();
    sample(8'h00, 32'h0);
    outs("R3 first sample no history", 4'b0000);
    sample(8'h00, 32'h0);
    outs("R3 held match ignored", 4'b0000);
    sample(8'h00, 32'h1);
    sample(8'h00, 32'h0);
    outs("R3 new match fires", 4'b1001);
    start_sense = 1'b1;
    rearm();
    sample(8'h00, 32'h0);
    sample(8'h00, 32'h5);
    outs("R3 mismatch sense fires", 4'b1001);

    // R4: off and reserved start codes fire at once; off ref/pause never act
    start_src = 2'd0; ref_src = 2'd0; pause_src = 2'd0;
    rearm();
    sample(8'hFF, 32'h0);
    outs("R4 off start fires first sample", 4'b1001);
    for (int k = 0; k < 8; k++) sample((k % 2 == 0) ? 8'h00 : 8'hFF, 32'h0);
    outs("R4 off ref and pause inactive", 4'b0001);
    start_src = 2'd3;
    rearm();
    sample(8'h00, 32'h0);
    outs("R4 reserved start code fires", 4'b1001);

    // R2: falling edge on line 2
    start_src = 2'd1; start_sel = 3'd2; start_sense = 1'b1;
    rearm();
    sample(8'h04, 32'h0);
    sample(8'h04, 32'h0);
    outs("R2 held high no falling edge", 4'b0000);
    sample(8'h00, 32'h0);
    outs("R2 falling edge starts", 4'b1001);

    // R6: reference edge before start is ignored, then fires once
    start_sel = 3'd0; start_sense = 1'b0;
    ref_src = 2'd1; ref_sel = 3'd3; ref_sense = 1'b0;
    rearm();
    sample(8'h00, 32'h0);
    sample(8'h08, 32'h0);
    outs("R6 ref before start ignored", 4'b0000);
    sample(8'h00, 32'h0);
    sample(8'h01, 32'h0);
    outs("R6 start", 4'b1001);
    sample(8'h09, 32'h0);
    outs("R6 ref fires", 4'b0101);
    sample(8'h01, 32'h0);
    sample(8'h09, 32'h0);
    outs("R6 ref only once", 4'b0001);

    // R5: disarm clears, next run starts afresh
    arm = 1'b0; idle(1);
    outs("R5 disarm clears", 4'b0000);

    // R7 R10: low-level pause with gaps between samples
    ref_src = 2'd0; start_src = 2'd0;
    pause_src = 2'd1; pause_sel = 3'd1; pause_sense = 1'b1;
    arm = 1'b1; idle(1);
    sample(8'h02, 32'h0);
    outs("R5 R7 start in new run", 4'b1001);
    for (int k = 0; k < 5; k++) sample(8'h00, 32'h0);
    outs("R7 not yet paused", 4'b0001);
    idle(3);
    outs("R10 no sample no progress", 4'b0001);
    sample(8'h00, 32'h0);
    outs("R7 R8 paused after latency", 4'b0010);

    // R9: generation mode refuses pattern start
    arm = 1'b0; idle(1);
    gen_mode = 1'b1; pause_src = 2'd0;
    start_src = 2'd2; start_sense = 1'b0;
    pat_value = 32'h0; pat_care = 32'hFFFF_FFFF;
    #1;
    chk("R9 reject flag", {31'd0, cfg_reject}, 32'd1);
    rearm();
    sample(8'h00, 32'h1);
    sample(8'h00, 32'h0);
    outs("R9 pattern start refused", 4'b0000);
    start_src = 2'd1;
    #1;
    chk("R9 reject clears for line source", {31'd0, cfg_reject}, 32'd0);
    gen_mode = 1'b0; arm = 1'b0;
    idle(2);
    finish_run();
  end

endmodule